// File: doc/BRIEF.md
# Segment-Selector-Tagged Translation Cache

This block turns a segment-relative address into a physical address for an MMU in which every segment has its own page directory. A request names one of the segment registers and gives a page number and a byte offset inside that segment. The block reads the global selector held in the named register. It then searches a small fully associative cache whose tags are the pair of global selector and page number. On a hit, the stored frame is joined to the offset and returned in the next cycle, and the segment descriptor is not consulted. On a miss, the page directory pointer of that selector's descriptor locates a one-level page table. The block reads that table through a simple memory request port and caches the result.

No segment base is ever added. The page table address is the directory pointer with the page number appended, and the physical address is the frame with the offset appended. Entries carry the global selector rather than the number a program used to name the segment. Software that reaches one segment through different segment registers, or that reloads a register, keeps sharing the cached translations. Software keeps the cache coherent with two commands: one drops every entry of one selector, the other drops everything.

Top module: `seg_tlb`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` and `mem_req_valid` are 0, and no entry is valid, so the first lookup of any page starts a walk.
- R2: A lookup whose selector and page are cached is accepted on a clock edge with `req_valid` and `req_ready` both high. `rsp_valid` is then high for one cycle after that edge, and no memory read is issued.
- R3: The returned physical address is the frame number in the upper bits with the request offset in the lower OFF_W bits. The page table read address is the directory pointer in the upper bits with the page number in the lower VPN_W bits. No addition takes part in either.
- R4: A hit returns the frame stored at fill time, even if the descriptor of that selector has been rewritten since then.
- R5: A miss takes the directory pointer from the descriptor of the selector currently held in the named segment register. It issues exactly one memory read. `mem_req_valid` and `mem_req_addr` hold steady until `mem_req_ready` is seen.
- R6: Entries are tagged with the global selector. Two segment registers holding the same selector share entries, and rewriting a segment register invalidates nothing.
- R7: A page table entry has its valid flag at bit PFN_W and the frame in bits PFN_W-1:0. A clear valid flag returns `rsp_fault`=1 with `rsp_pa`=0 and caches nothing, so a repeated lookup walks again.
- R8: The cache holds ENTRIES translations (8 by default). Fills go to slots in round-robin order starting from slot 0, so the (ENTRIES+1)-th fill evicts the first one.
- R9: A selector invalidate removes only the entries tagged with that selector.
- R10: An invalidate-all removes every entry.
- R11: While a walk is in progress `req_ready` is 0, so only one request is ever outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seg_wr_en | input | 1 | Write a global selector into a segment register |
| seg_wr_idx | input | SEG_IDX_W | Segment register to write |
| seg_wr_sel | input | SEL_W | Global selector to store |
| dsc_wr_en | input | 1 | Write a descriptor's directory pointer |
| dsc_wr_sel | input | SEL_W | Selector whose descriptor is written |
| dsc_wr_pdp | input | PDP_W | Page directory pointer |
| inv_sel_en | input | 1 | Drop entries tagged with `inv_sel` |
| inv_sel | input | SEL_W | Selector to drop |
| inv_all | input | 1 | Drop all entries |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Block can accept a lookup |
| req_seg | input | SEG_IDX_W | Segment register named by the lookup |
| req_vpn | input | VPN_W | Segment-relative page number |
| req_off | input | OFF_W | Byte offset within the page |
| rsp_valid | output | 1 | Result valid (one-cycle pulse) |
| rsp_pa | output | PFN_W+OFF_W | Physical address |
| rsp_fault | output | 1 | Page table entry was not valid |
| mem_req_valid | output | 1 | Page table read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | PDP_W+VPN_W | Page table entry address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | PFN_W+1 | Page table entry |

## Verification
Page number sweeps run through one segment register, first against an empty cache and then again. This separates walks from hits. Because the table content is a function in which some addresses carry a clear valid flag, the same sweep also shows that faults fill nothing. A second segment register holding the same selector, a reloaded register and a rewritten descriptor then show that the tag is the global selector and that hits never read the descriptor. Filling past eight entries from a second selector, followed by selector and full invalidates, shows the round-robin victim order and which entries each command removes. The memory model adds varying acceptance latency, to test the request hold and the blocked request channel during a walk.

// File: rtl/seg_tlb_pkg.sv
package seg_tlb_pkg;
  typedef enum logic [1:0] {
    WALK_IDLE  = 2'd0,
    WALK_REQ   = 2'd1,
    WALK_WAIT  = 2'd2
  } walk_state_e;
endpackage

// File: rtl/seg_file.sv
// Segment registers holding global selectors, plus the global descriptor
// table that supplies each selector's page directory pointer.
module seg_file #(
  parameter int NSEG  = 4,
  parameter int SEL_W = 4,
  parameter int PDP_W = 6,
  localparam int SEG_IDX_W = (NSEG > 1) ? $clog2(NSEG) : 1,
  localparam int NDSC = 1 << SEL_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 seg_wr_en,
  input  logic [SEG_IDX_W-1:0] seg_wr_idx,
  input  logic [SEL_W-1:0]     seg_wr_sel,
  input  logic                 dsc_wr_en,
  input  logic [SEL_W-1:0]     dsc_wr_sel,
  input  logic [PDP_W-1:0]     dsc_wr_pdp,
  input  logic [SEG_IDX_W-1:0] rd_idx,
  output logic [SEL_W-1:0]     rd_sel,
  output logic [PDP_W-1:0]     rd_pdp
);
  logic [SEL_W-1:0] seg_q [NSEG];
  logic [PDP_W-1:0] dsc_q [NDSC];

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    logic seg_en;
    assign seg_en = seg_wr_en && (seg_wr_idx == SEG_IDX_W'(s));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      seg_q[s] <= '0;
      else if (seg_en) seg_q[s] <= seg_wr_sel;
    end
  end

  for (genvar d = 0; d < NDSC; d++) begin : g_dsc
    logic dsc_en;
    assign dsc_en = dsc_wr_en && (dsc_wr_sel == SEL_W'(d));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dsc_q[d] <= '0;
      else if (dsc_en) dsc_q[d] <= dsc_wr_pdp;
    end
  end

  assign rd_sel = seg_q[rd_idx];
  assign rd_pdp = dsc_q[rd_sel];
endmodule

// File: rtl/tlb_cam.sv
// Fully associative store tagged by {global selector, page}; round-robin fill.
module tlb_cam #(
  parameter int ENTRIES = 8,
  parameter int SEL_W   = 4,
  parameter int VPN_W   = 6,
  parameter int PFN_W   = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] lk_sel,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [PFN_W-1:0] lk_pfn,
  input  logic             fill_en,
  input  logic [SEL_W-1:0] fill_sel,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic             inv_sel_en,
  input  logic [SEL_W-1:0] inv_sel,
  input  logic             inv_all
);
  logic [ENTRIES-1:0] vld_q, vld_d, hit_vec;
  logic [SEL_W-1:0]   sel_q [ENTRIES];
  logic [VPN_W-1:0]   vpn_q [ENTRIES];
  logic [PFN_W-1:0]   pfn_q [ENTRIES];
  logic [IDX_W-1:0]   rr_q, rr_d;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic slot_fill;
    assign slot_fill  = fill_en && (rr_q == IDX_W'(e));
    assign hit_vec[e] = vld_q[e] && (sel_q[e] == lk_sel) && (vpn_q[e] == lk_vpn);

    always_comb begin
      vld_d[e] = vld_q[e];
      if (inv_all)                                vld_d[e] = 1'b0;
      else if (inv_sel_en && sel_q[e] == inv_sel) vld_d[e] = 1'b0;
      if (slot_fill)                              vld_d[e] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sel_q[e] <= '0;
        vpn_q[e] <= '0;
        pfn_q[e] <= '0;
      end else if (slot_fill) begin
        sel_q[e] <= fill_sel;
        vpn_q[e] <= fill_vpn;
        pfn_q[e] <= fill_pfn;
      end
    end
  end

  always_comb begin
    lk_pfn = '0;
    for (int e = 0; e < ENTRIES; e++)
      if (hit_vec[e]) lk_pfn = lk_pfn | pfn_q[e];
  end
  assign lk_hit = |hit_vec;

  always_comb begin
    rr_d = rr_q;
    if (fill_en) rr_d = (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      rr_q  <= '0;
    end else begin
      vld_q <= vld_d;
      rr_q  <= rr_d;
    end
  end

  // R8: fills only happen on a miss, so a tag never sits in two slots
  a_r8_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
  // R10: a full invalidate leaves nothing valid unless a fill lands with it
  a_r10_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all && !fill_en |=> vld_q == '0);
endmodule

// File: rtl/walk_ctrl.sv
// Lookup acceptance, hit response and single-level page table walk.
module walk_ctrl
  import seg_tlb_pkg::*;
#(
  parameter int SEL_W = 4,
  parameter int VPN_W = 6,
  parameter int OFF_W = 6,
  parameter int PFN_W = 8,
  parameter int PDP_W = 6,
  localparam int PA_W    = PFN_W + OFF_W,
  localparam int MADDR_W = PDP_W + VPN_W,
  localparam int PTE_W   = PFN_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VPN_W-1:0]   req_vpn,
  input  logic [OFF_W-1:0]   req_off,
  input  logic [SEL_W-1:0]   cur_sel,
  input  logic [PDP_W-1:0]   cur_pdp,
  input  logic               lk_hit,
  input  logic [PFN_W-1:0]   lk_pfn,
  output logic               rsp_valid,
  output logic [PA_W-1:0]    rsp_pa,
  output logic               rsp_fault,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [MADDR_W-1:0] mem_req_addr,
  input  logic               mem_rsp_valid,
  input  logic [PTE_W-1:0]   mem_rsp_data,
  output logic               fill_en,
  output logic [SEL_W-1:0]   fill_sel,
  output logic [VPN_W-1:0]   fill_vpn,
  output logic [PFN_W-1:0]   fill_pfn
);
  walk_state_e       st_q, st_d;
  logic [SEL_W-1:0]  sel_q;
  logic [VPN_W-1:0]  vpn_q;
  logic [OFF_W-1:0]  off_q;
  logic [PDP_W-1:0]  pdp_q;
  logic              rv_q, rv_d;
  logic [PA_W-1:0]   pa_q, pa_d;
  logic              flt_q, flt_d;
  logic              accept, cap_en, pte_ok, walk_done;

  assign req_ready = (st_q == WALK_IDLE);
  assign accept    = req_valid && req_ready;
  assign cap_en    = accept && !lk_hit;
  assign pte_ok    = mem_rsp_data[PFN_W];
  assign walk_done = (st_q == WALK_WAIT) && mem_rsp_valid;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      WALK_IDLE: if (cap_en)        st_d = WALK_REQ;
      WALK_REQ:  if (mem_req_ready) st_d = WALK_WAIT;
      WALK_WAIT: if (mem_rsp_valid) st_d = WALK_IDLE;
      default:                      st_d = WALK_IDLE;
    endcase
  end

  always_comb begin
    rv_d  = 1'b0;
    pa_d  = pa_q;
    flt_d = flt_q;
    if (accept && lk_hit) begin
      rv_d  = 1'b1;
      pa_d  = {lk_pfn, req_off};
      flt_d = 1'b0;
    end else if (walk_done) begin
      rv_d  = 1'b1;
      pa_d  = pte_ok ? {mem_rsp_data[PFN_W-1:0], off_q} : '0;
      flt_d = !pte_ok;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= WALK_IDLE;
      rv_q  <= 1'b0;
      pa_q  <= '0;
      flt_q <= 1'b0;
    end else begin
      st_q <= st_d;
      rv_q <= rv_d;
      if (rv_d) begin
        pa_q  <= pa_d;
        flt_q <= flt_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      vpn_q <= '0;
      off_q <= '0;
      pdp_q <= '0;
    end else if (cap_en) begin
      sel_q <= cur_sel;
      vpn_q <= req_vpn;
      off_q <= req_off;
      pdp_q <= cur_pdp;
    end
  end

  assign rsp_valid     = rv_q;
  assign rsp_pa        = pa_q;
  assign rsp_fault     = flt_q;
  assign mem_req_valid = (st_q == WALK_REQ);
  assign mem_req_addr  = {pdp_q, vpn_q};
  assign fill_en       = walk_done && pte_ok;
  assign fill_sel      = sel_q;
  assign fill_vpn      = vpn_q;
  assign fill_pfn      = mem_rsp_data[PFN_W-1:0];

  // R5: a pending page table read keeps its request and address
  a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
  // R11: no new lookup while a read is outstanding
  a_r11_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);
endmodule

// File: rtl/seg_tlb.sv
module seg_tlb #(
  parameter int NSEG    = 4,
  parameter int SEL_W   = 4,
  parameter int VPN_W   = 6,
  parameter int OFF_W   = 6,
  parameter int PFN_W   = 8,
  parameter int PDP_W   = 6,
  parameter int ENTRIES = 8,
  localparam int SEG_IDX_W = (NSEG > 1) ? $clog2(NSEG) : 1,
  localparam int PA_W      = PFN_W + OFF_W,
  localparam int MADDR_W   = PDP_W + VPN_W,
  localparam int PTE_W     = PFN_W + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 seg_wr_en,
  input  logic [SEG_IDX_W-1:0] seg_wr_idx,
  input  logic [SEL_W-1:0]     seg_wr_sel,
  input  logic                 dsc_wr_en,
  input  logic [SEL_W-1:0]     dsc_wr_sel,
  input  logic [PDP_W-1:0]     dsc_wr_pdp,
  input  logic                 inv_sel_en,
  input  logic [SEL_W-1:0]     inv_sel,
  input  logic                 inv_all,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [SEG_IDX_W-1:0] req_seg,
  input  logic [VPN_W-1:0]     req_vpn,
  input  logic [OFF_W-1:0]     req_off,
  output logic                 rsp_valid,
  output logic [PA_W-1:0]      rsp_pa,
  output logic                 rsp_fault,
  output logic                 mem_req_valid,
  input  logic                 mem_req_ready,
  output logic [MADDR_W-1:0]   mem_req_addr,
  input  logic                 mem_rsp_valid,
  input  logic [PTE_W-1:0]     mem_rsp_data
);
  logic [SEL_W-1:0] cur_sel;
  logic [PDP_W-1:0] cur_pdp;
  logic             lk_hit;
  logic [PFN_W-1:0] lk_pfn;
  logic             fill_en;
  logic [SEL_W-1:0] fill_sel;
  logic [VPN_W-1:0] fill_vpn;
  logic [PFN_W-1:0] fill_pfn;

  seg_file #(.NSEG(NSEG), .SEL_W(SEL_W), .PDP_W(PDP_W)) u_segs (
    .clk(clk), .rst_n(rst_n),
    .seg_wr_en(seg_wr_en), .seg_wr_idx(seg_wr_idx), .seg_wr_sel(seg_wr_sel),
    .dsc_wr_en(dsc_wr_en), .dsc_wr_sel(dsc_wr_sel), .dsc_wr_pdp(dsc_wr_pdp),
    .rd_idx(req_seg), .rd_sel(cur_sel), .rd_pdp(cur_pdp)
  );

  tlb_cam #(.ENTRIES(ENTRIES), .SEL_W(SEL_W), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_cam (
    .clk(clk), .rst_n(rst_n),
    .lk_sel(cur_sel), .lk_vpn(req_vpn), .lk_hit(lk_hit), .lk_pfn(lk_pfn),
    .fill_en(fill_en), .fill_sel(fill_sel), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
    .inv_sel_en(inv_sel_en), .inv_sel(inv_sel), .inv_all(inv_all)
  );

  walk_ctrl #(.SEL_W(SEL_W), .VPN_W(VPN_W), .OFF_W(OFF_W), .PFN_W(PFN_W),
              .PDP_W(PDP_W)) u_walk (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_vpn(req_vpn), .req_off(req_off),
    .cur_sel(cur_sel), .cur_pdp(cur_pdp),
    .lk_hit(lk_hit), .lk_pfn(lk_pfn),
    .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .fill_en(fill_en), .fill_sel(fill_sel), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn)
  );

  // R2: a hit answers in the next cycle and touches no memory
  a_r2_hit_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && lk_hit |=> rsp_valid && !mem_req_valid);
  // R7: a faulting response carries a zero address
  a_r7_fault_zero_pa: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_pa == '0);
endmodule

// File: tb/seg_tlb_test.sv
module seg_tlb_test;
  localparam int SEL_W = 4, VPN_W = 6, OFF_W = 6, PFN_W = 8, PDP_W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic seg_wr_en = 0, dsc_wr_en = 0, inv_sel_en = 0, inv_all = 0, req_valid = 0;
  logic [1:0] seg_wr_idx = 0, req_seg = 0;
  logic [SEL_W-1:0] seg_wr_sel = 0, dsc_wr_sel = 0, inv_sel = 0;
  logic [PDP_W-1:0] dsc_wr_pdp = 0;
  logic [VPN_W-1:0] req_vpn = 0;
  logic [OFF_W-1:0] req_off = 0;
  logic req_ready, rsp_valid, rsp_fault, mem_req_valid;
  logic [PFN_W+OFF_W-1:0] rsp_pa;
  logic [PDP_W+VPN_W-1:0] mem_req_addr;
  logic mem_req_ready = 0, mem_rsp_valid = 0;
  logic [PFN_W:0] mem_rsp_data = 0;

  int total = 0, bad = 0, walks = 0, mem_lat = 0;
  int last_addr = 0;

  seg_tlb uut (
    .clk(clk), .rst_n(rst_n),
    .seg_wr_en(seg_wr_en), .seg_wr_idx(seg_wr_idx), .seg_wr_sel(seg_wr_sel),
    .dsc_wr_en(dsc_wr_en), .dsc_wr_sel(dsc_wr_sel), .dsc_wr_pdp(dsc_wr_pdp),
    .inv_sel_en(inv_sel_en), .inv_sel(inv_sel), .inv_all(inv_all),
    .req_valid(req_valid), .req_ready(req_ready), .req_seg(req_seg),
    .req_vpn(req_vpn), .req_off(req_off),
    .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  // Page table content: an entry is valid unless its address is a multiple of 7.
  function automatic logic pte_ok(int a);
    return (a % 7) != 0;
  endfunction
  function automatic logic [PFN_W-1:0] pte_pfn(int a);
    return PFN_W'((a * 37 + 11) & 255);
  endfunction

  task automatic chk(input logic ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // Memory model with adjustable acceptance latency.
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        repeat (mem_lat) @(negedge clk);
        mem_req_ready = 1;
        last_addr = int'(mem_req_addr);
        walks++;
        @(negedge clk);
        mem_req_ready = 0;
        @(negedge clk);
        mem_rsp_valid = 1;
        mem_rsp_data = {pte_ok(last_addr), pte_pfn(last_addr)};
        @(negedge clk);
        mem_rsp_valid = 0;
      end
    end
  end

  task automatic set_seg(input int idx, input int sel);
    @(negedge clk); seg_wr_en = 1; seg_wr_idx = 2'(idx); seg_wr_sel = SEL_W'(sel);
    @(negedge clk); seg_wr_en = 0;
  endtask
  task automatic set_dsc(input int sel, input int pdp);
    @(negedge clk); dsc_wr_en = 1; dsc_wr_sel = SEL_W'(sel); dsc_wr_pdp = PDP_W'(pdp);
    @(negedge clk); dsc_wr_en = 0;
  endtask

  // One lookup; checks the result, the walk count, hit latency and walk address.
  task automatic lookup(input int seg, input int vpn, input int off, input int pdp,
                        input int exp_walk, input string rq);
    int a, w0, cyc, exp_pa;
    logic exp_f;
    a = pdp * 64 + vpn;
    exp_f = !pte_ok(a);
    exp_pa = exp_f ? 0 : int'({pte_pfn(a), OFF_W'(off)});
    @(negedge clk);
    w0 = walks;
    req_valid = 1; req_seg = 2'(seg); req_vpn = VPN_W'(vpn); req_off = OFF_W'(off);
    @(negedge clk);
    req_valid = 0;
    cyc = 1;
    if (exp_walk != 0)
      chk(!req_ready && mem_req_valid, {rq, " R11 busy during walk"}, int'(req_ready), 0);
    while (!rsp_valid && cyc < 60) begin
      @(negedge clk);
      cyc++;
    end
    if (exp_walk == 0) chk(cyc == 1, {rq, " R2 hit latency"}, cyc, 1);
    chk(rsp_valid, {rq, " response seen"}, int'(rsp_valid), 1);
    chk(int'(rsp_pa) == exp_pa, {rq, " R3 physical address"}, int'(rsp_pa), exp_pa);
    chk(rsp_fault == exp_f, {rq, " R7 fault flag"}, int'(rsp_fault), int'(exp_f));
    chk(walks - w0 == exp_walk, {rq, " walk count"}, walks - w0, exp_walk);
    if (exp_walk != 0) chk(last_addr == a, {rq, " R5 table address"}, last_addr, a);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready == 1, "R1 req_ready", int'(req_ready), 1);
    chk(rsp_valid == 0, "R1 rsp_valid", int'(rsp_valid), 0);
    chk(mem_req_valid == 0, "R1 mem_req_valid", int'(mem_req_valid), 0);

    for (int s = 0; s < 16; s++) set_dsc(s, s * 3 + 1);   // sel 2 -> 7, sel 5 -> 16
    set_seg(0, 2); set_seg(1, 5); set_seg(2, 2); set_seg(3, 9);

    // R1/R7 cold sweep: every page walks; pages 0 and 7 fault (address multiple of 7)
    for (int v = 0; v < 8; v++) begin
      mem_lat = v % 3;
      lookup(0, v, v * 5 + 1, 7, 1, "R1 cold sweep");
    end
    // R2/R7 warm sweep: valid pages hit, faulting pages walk again
    for (int v = 0; v < 8; v++)
      lookup(0, v, 63 - v, 7, (v == 0 || v == 7) ? 1 : 0, "R2 R7 warm sweep");

    // R6 shared selector through another register, and after a register reload
    for (int v = 1; v < 7; v++) lookup(2, v, v, 7, 0, "R6 shared selector");
    set_seg(3, 2);
    lookup(3, 3, 9, 7, 0, "R6 reloaded register");
    lookup(0, 4, 9, 7, 0, "R6 original register");

    // R4 descriptor rewrite does not affect hits
    set_dsc(2, 20);
    lookup(0, 2, 17, 7, 0, "R4 stale descriptor hit");

    // R8 round robin: four sel-5 fills land in slots 6,7,0,1 evicting sel-2 pages 1,2
    mem_lat = 4;
    for (int v = 0; v < 4; v++) lookup(1, v, v, 16, 1, "R8 fill");
    for (int v = 3; v < 7; v++) lookup(0, v, 2, 7, 0, "R8 survivor");
    for (int v = 0; v < 4; v++) lookup(1, v, 3, 16, 0, "R8 new entry hit");
    lookup(0, 1, 5, 20, 1, "R5 R8 evicted page walks new directory");
    lookup(0, 2, 5, 20, 1, "R8 evicted page refill");
    lookup(0, 3, 5, 20, 1, "R8 slot2 fill evicted page 3");

    // R9 selector invalidate: sel 5 gone, sel 2 page 6 kept
    @(negedge clk); inv_sel_en = 1; inv_sel = 4'd5;
    @(negedge clk); inv_sel_en = 0;
    lookup(0, 6, 1, 7, 0, "R9 other selector kept");
    lookup(1, 0, 1, 16, 1, "R9 invalidated selector walks");
    lookup(1, 1, 1, 16, 1, "R9 invalidated selector walks");

    // R10 invalidate all
    @(negedge clk); inv_all = 1;
    @(negedge clk); inv_all = 0;
    mem_lat = 2;
    lookup(0, 6, 4, 20, 1, "R10 all dropped");
    lookup(1, 0, 4, 16, 1, "R10 all dropped");
    lookup(0, 6, 8, 20, 0, "R10 refilled hit");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule